// File: doc/BRIEF.md
# Frame-Aligned Audio Clock Divider

This block turns a fast master audio clock, running at a fixed multiple of the sample rate, into the bit-rate and frame-rate timing of an audio link. It does this by counting only, with no phase-locked loop. A word clock, whose rising edge marks the start of each sample frame, comes in beside the master clock. The divider snaps its frame counter onto that edge. From then on it checks every frame that the next word-clock edge arrives exactly where the counter expects it.

The master-to-sample ratio can be 256, 384 or 512. In each case the bit clock runs at 64 times the sample rate, so one bit period lasts 4, 6 or 8 master cycles. A lock flag rises once the word clock has proved steady for several frames in a row. A one-cycle error pulse and a loss of lock flag an edge that comes early, late or not at all. The next edge then pulls the counter back into phase. A ratio change waits for the next frame boundary, and lock must then be regained.

Top module: `frame_clk_divider`

## Requirements
- R1: The ratio select code chooses the frame length in master cycles: 00 gives 256, 01 gives 384, 10 gives 512 and 11 gives 256. The frame strobe is high for exactly one master cycle per frame, at frame count zero.
- R2: The word-clock input first seen high at master clock edge k makes the frame strobe high in the cycle that follows edge k+2. This is a fixed latency of three master cycles from the input to the frame start.
- R3: The bit clock enable pulses every ratio/64 master cycles, starting at frame count zero, which gives 64 pulses per frame. The bit clock level is high for the first half of each bit period (3 high and 3 low at ratio 384).
- R4: The frame clock is high for the first ratio/2 cycles of the frame, counting from the strobe cycle, and low for the rest.
- R5: While the divider is not aligned, the first word-clock rising edge loads the frame count with zero and raises no error.
- R6: Lock rises in the cycle of the frame start produced by the fourth on-time word-clock edge after an alignment, and not earlier.
- R7: A word-clock edge at any frame count other than the wrap is misplaced. It gives a one-cycle error pulse and drops lock. The next edge realigns the counter without error.
- R8: A wrap with no word-clock edge while the divider is aligned gives a one-cycle error pulse and drops lock. While the divider is unaligned, a missing edge raises no error.
- R9: A ratio change waits until the next frame boundary. At that boundary the divider drops lock without an error, and the next edge realigns it at the new ratio.
- R10: During reset, lock and error are low and the frame count is zero, so the strobe and the frame clock are high.
- R11: Code 11 behaves as 256. Selecting it while 256 is active does not disturb lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wclk_in | input | 1 | Word clock; rising edge marks a frame start; asynchronous to mclk |
| ratio_sel | input | 2 | Master-to-sample ratio code, synchronous to mclk |
| bclk | output | 1 | Bit clock level |
| bclk_en | output | 1 | One-cycle pulse at the start of each bit period |
| fclk | output | 1 | Regenerated frame clock |
| frame_stb | output | 1 | One-cycle pulse at frame count zero |
| lock | output | 1 | Word clock has been on time for the required run of frames |
| align_err | output | 1 | One-cycle pulse on a misplaced or missing word-clock edge |

## Verification
The bench builds the block with its default parameters: all three ratios, 64 bits per frame, a lock run of four frames and a two-stage synchronizer. Frames are therefore short enough that every master cycle of several locked frames can be compared at each ratio. It compares the strobe, frame clock, bit clock and bit enable against a frame phase it computes from its own word-clock generator. With the same settings it also steps through the exact lock cycle, early and missing edges, the deferred ratio change and the reserved code.

// File: rtl/fcd_pkg.sv
// Package: shared types for the frame-aligned clock divider.
// Assumes a two-bit ratio select; the reserved code folds onto the default ratio.
package fcd_pkg;

    typedef enum logic [1:0] {
        RC_X256 = 2'd0,
        RC_X384 = 2'd1,
        RC_X512 = 2'd2,
        RC_RSVD = 2'd3
    } ratio_code_t;

    // Map a raw select code onto a supported ratio; reserved folds to x256.
    function automatic ratio_code_t normalize_code(input logic [1:0] raw);
        ratio_code_t code;
        case (raw)
            2'd1:    code = RC_X384;
            2'd2:    code = RC_X512;
            default: code = RC_X256;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/fcd_wc_sync.sv
// Module: fcd_wc_sync
// Brings the word clock into the master clock domain through a flop chain and
// flags its rising edge. Assumes the word clock is far slower than the master clock.
module fcd_wc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stages settle the sample further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[gi] <= 1'b0;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    // Holds the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/fcd_ratio_select.sv
// Module: fcd_ratio_select
// Holds the active ratio and gives out the frame and bit-period limits for it.
// A new request takes effect only at a frame boundary reported by the counter.
module fcd_ratio_select
    import fcd_pkg::*;
#(
    parameter int RATIO_A        = 256,
    parameter int RATIO_B        = 384,
    parameter int RATIO_C        = 512,
    parameter int BITS_PER_FRAME = 64,
    parameter int CW             = 9,
    parameter int BW             = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_raw,
    input  logic          boundary,
    output logic [CW-1:0] frame_last,
    output logic [CW-1:0] frame_half,
    output logic [BW-1:0] div_last,
    output logic [BW-1:0] div_half,
    output logic          ratio_switch
);

    localparam int DIV_A = RATIO_A / BITS_PER_FRAME;
    localparam int DIV_B = RATIO_B / BITS_PER_FRAME;
    localparam int DIV_C = RATIO_C / BITS_PER_FRAME;

    ratio_code_t active;
    ratio_code_t requested;

    assign requested    = normalize_code(sel_raw);
    assign ratio_switch = boundary && (requested != active);

    // Active ratio: taken from the select at reset, updated only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            active <= requested;
        else if (ratio_switch) active <= requested;
    end

    // Decode the per-ratio limits from the active code.
    always_comb begin
        case (active)
            RC_X384: begin
                frame_last = CW'(RATIO_B - 1);
                frame_half = CW'(RATIO_B / 2);
                div_last   = BW'(DIV_B - 1);
                div_half   = BW'(DIV_B / 2);
            end
            RC_X512: begin
                frame_last = CW'(RATIO_C - 1);
                frame_half = CW'(RATIO_C / 2);
                div_last   = BW'(DIV_C - 1);
                div_half   = BW'(DIV_C / 2);
            end
            default: begin
                frame_last = CW'(RATIO_A - 1);
                frame_half = CW'(RATIO_A / 2);
                div_last   = BW'(DIV_A - 1);
                div_half   = BW'(DIV_A / 2);
            end
        endcase
    end

endmodule

// File: rtl/fcd_frame_counter.sv
// Module: fcd_frame_counter
// Counts master cycles within a frame and within a bit period, and decodes the
// frame strobe, frame clock and bit clock from them. The count is forced to
// zero on an alignment load; otherwise it wraps at the limit it is given.
module fcd_frame_counter #(
    parameter int CW = 9,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] frame_last,
    input  logic [CW-1:0] frame_half,
    input  logic [BW-1:0] div_last,
    input  logic [BW-1:0] div_half,
    output logic          at_last,
    output logic          boundary,
    output logic          frame_stb,
    output logic          fclk,
    output logic          bclk,
    output logic          bclk_en
);

    logic [CW-1:0] frame_cnt;
    logic [BW-1:0] bit_cnt;

    assign at_last  = (frame_cnt == frame_last);
    assign boundary = load || at_last;

    // Frame position: restart at a boundary, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_cnt <= '0;
        else if (boundary) frame_cnt <= '0;
        else               frame_cnt <= frame_cnt + CW'(1);
    end

    // Bit position: restarts with the frame and at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bit_cnt <= '0;
        else if (boundary || bit_cnt == div_last) bit_cnt <= '0;
        else                                     bit_cnt <= bit_cnt + BW'(1);
    end

    assign frame_stb = (frame_cnt == '0);
    assign fclk      = (frame_cnt < frame_half);
    assign bclk_en   = (bit_cnt == '0);
    assign bclk      = (bit_cnt < div_half);

endmodule

// File: rtl/fcd_lock_monitor.sv
// Module: fcd_lock_monitor
// Tracks whether the frame counter is aligned to the word clock, counts
// consecutive on-time edges to declare lock, and pulses an error on a
// misplaced or missing edge. Assumes at most one word-clock edge per frame.
module fcd_lock_monitor #(
    parameter int LOCK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic at_last,
    input  logic ratio_switch,
    output logic aligned,
    output logic lock,
    output logic err
);

    localparam int GW = $clog2(LOCK_FRAMES + 1);

    logic [GW-1:0] good_cnt;
    logic [GW-1:0] good_nxt;
    logic          aligned_nxt;
    logic          lock_nxt;
    logic          err_nxt;

    // Next-state decision for alignment, run length, lock and error.
    always_comb begin
        aligned_nxt = aligned;
        good_nxt    = good_cnt;
        lock_nxt    = lock;
        err_nxt     = 1'b0;
        if (ratio_switch) begin
            aligned_nxt = 1'b0;
            good_nxt    = '0;
            lock_nxt    = 1'b0;
        end else if (aligned) begin
            if (rise && at_last) begin
                if (good_cnt != GW'(LOCK_FRAMES)) good_nxt = good_cnt + GW'(1);
                if (good_cnt >= GW'(LOCK_FRAMES - 1)) lock_nxt = 1'b1;
            end else if (rise || at_last) begin
                err_nxt     = 1'b1;
                aligned_nxt = 1'b0;
                good_nxt    = '0;
                lock_nxt    = 1'b0;
            end
        end else if (rise) begin
            aligned_nxt = 1'b1;
            good_nxt    = '0;
        end
    end

    // State registers for the monitor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned  <= 1'b0;
            good_cnt <= '0;
            lock     <= 1'b0;
            err      <= 1'b0;
        end else begin
            aligned  <= aligned_nxt;
            good_cnt <= good_nxt;
            lock     <= lock_nxt;
            err      <= err_nxt;
        end
    end

endmodule

// File: rtl/frame_clk_divider.sv
// Module: frame_clk_divider
// Derives bit and frame timing from a master audio clock by counting,
// phase-aligned to an external word clock and continuously checked against it.
// Assumes ratio_sel is synchronous to mclk and each ratio is a multiple of
// BITS_PER_FRAME.
module frame_clk_divider #(
    parameter int RATIO_A        = 256,
    parameter int RATIO_B        = 384,
    parameter int RATIO_C        = 512,
    parameter int BITS_PER_FRAME = 64,
    parameter int LOCK_FRAMES    = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       wclk_in,
    input  logic [1:0] ratio_sel,
    output logic       bclk,
    output logic       bclk_en,
    output logic       fclk,
    output logic       frame_stb,
    output logic       lock,
    output logic       align_err
);

    localparam int RATIO_AB  = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
    localparam int RATIO_MAX = (RATIO_AB > RATIO_C) ? RATIO_AB : RATIO_C;
    localparam int CW        = $clog2(RATIO_MAX);
    localparam int DIV_MAX   = RATIO_MAX / BITS_PER_FRAME;
    localparam int BW        = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

    logic          wc_rise;
    logic          aligned;
    logic          load;
    logic          at_last;
    logic          boundary;
    logic          ratio_switch;
    logic [CW-1:0] frame_last;
    logic [CW-1:0] frame_half;
    logic [BW-1:0] div_last;
    logic [BW-1:0] div_half;

    assign load = wc_rise && !aligned;

    fcd_wc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (mclk),
        .rst_n    (rst_n),
        .async_in (wclk_in),
        .rise     (wc_rise)
    );

    fcd_ratio_select #(
        .RATIO_A        (RATIO_A),
        .RATIO_B        (RATIO_B),
        .RATIO_C        (RATIO_C),
        .BITS_PER_FRAME (BITS_PER_FRAME),
        .CW             (CW),
        .BW             (BW)
    ) u_ratio (
        .clk          (mclk),
        .rst_n        (rst_n),
        .sel_raw      (ratio_sel),
        .boundary     (boundary),
        .frame_last   (frame_last),
        .frame_half   (frame_half),
        .div_last     (div_last),
        .div_half     (div_half),
        .ratio_switch (ratio_switch)
    );

    fcd_frame_counter #(
        .CW (CW),
        .BW (BW)
    ) u_count (
        .clk        (mclk),
        .rst_n      (rst_n),
        .load       (load),
        .frame_last (frame_last),
        .frame_half (frame_half),
        .div_last   (div_last),
        .div_half   (div_half),
        .at_last    (at_last),
        .boundary   (boundary),
        .frame_stb  (frame_stb),
        .fclk       (fclk),
        .bclk       (bclk),
        .bclk_en    (bclk_en)
    );

    fcd_lock_monitor #(
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_lock (
        .clk          (mclk),
        .rst_n        (rst_n),
        .rise         (wc_rise),
        .at_last      (at_last),
        .ratio_switch (ratio_switch),
        .aligned      (aligned),
        .lock         (lock),
        .err          (align_err)
    );

endmodule

// File: rtl/fcd_checker.sv
// Module: fcd_checker
// Temporal properties on the divider's outputs, attached by bind below.
module fcd_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_stb,
    input logic fclk,
    input logic bclk,
    input logic bclk_en,
    input logic lock,
    input logic align_err
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |=> !frame_stb); // R1
    AST_STROBE_BIT_START: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |-> bclk_en); // R3
    AST_BIT_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bclk_en |-> bclk); // R3
    AST_STROBE_FCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) frame_stb |-> fclk); // R4
    AST_LOCK_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock) |-> frame_stb); // R6
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) align_err |=> !align_err); // R7
    AST_ERR_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n) align_err |-> !lock); // R8

endmodule

bind frame_clk_divider fcd_checker u_fcd_checker (
    .clk       (mclk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .fclk      (fclk),
    .bclk      (bclk),
    .bclk_en   (bclk_en),
    .lock      (lock),
    .align_err (align_err)
);

// File: tb/frame_clk_divider_bench.sv
`timescale 1ns/1ps
module frame_clk_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk_in = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       bclk, bclk_en, fclk, frame_stb, lock, align_err;

    int  checks = 0;
    int  fails = 0;
    int  t = 0;
    int  t0 = 0;
    int  per = 256;
    bit  wc_on = 1'b0;
    bit  wave_en = 1'b0;
    bit  noerr_en = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    frame_clk_divider u_frame_clk_divider (
        .mclk      (mclk_w),
        .rst_n     (rst_n),
        .wclk_in   (wclk_in),
        .ratio_sel (ratio_sel),
        .bclk      (bclk),
        .bclk_en   (bclk_en),
        .fclk      (fclk),
        .frame_stb (frame_stb),
        .lock      (lock),
        .align_err (align_err)
    );

    wire mclk_w = clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at t=%0d: got %0d expected %0d", req, what, t, act, exp);
        end
    endtask

    // One master cycle: sample at the falling edge, then drive the word clock.
    task automatic step();
        @(negedge clk);
        t++;
        if (wave_en && lock) begin
            int e;
            int dv;
            e  = ((t - t0 - 3) % per + per) % per;
            dv = per / 64;
            chk("R1/R2", "frame_stb", int'(frame_stb), int'(e == 0));
            chk("R4", "fclk", int'(fclk), int'(e < per / 2));
            chk("R3", "bclk_en", int'(bclk_en), int'((e % dv) == 0));
            chk("R3", "bclk", int'(bclk), int'((e % dv) < dv / 2));
        end
        if (noerr_en) chk("R8", "align_err while unaligned", int'(align_err), 0);
        if (wc_on && rst_n) wclk_in = (((t - t0) % per) < per / 2);
        else                wclk_in = 1'b0;
    endtask

    task automatic run_until(input int target);
        while (t < target) step();
    endtask

    task automatic do_reset(input logic [1:0] code);
        wc_on     = 1'b0;
        ratio_sel = code;
        rst_n     = 1'b0;
        repeat (4) step();
        chk("R10", "lock in reset", int'(lock), 0);
        chk("R10", "align_err in reset", int'(align_err), 0);
        chk("R10", "frame_stb in reset", int'(frame_stb), 1);
        chk("R10", "fclk in reset", int'(fclk), 1);
        rst_n = 1'b1;
        repeat (20) step();
    endtask

    task automatic start_wc(input int p);
        per   = p;
        t0    = t + 1;
        wc_on = 1'b1;
    endtask

    // Reach lock from an unaligned state and check its exact cycle.
    task automatic acquire(input string req);
        run_until(t0 + 3);
        chk("R5", "strobe after first edge", int'(frame_stb), 1);
        chk("R5", "no error on alignment", int'(align_err), 0);
        run_until(t0 + 4 * per + 2);
        chk(req, "lock before fourth on-time frame", int'(lock), 0);
        step();
        chk(req, "lock at fourth on-time frame", int'(lock), 1);
    endtask

    function automatic int next_rise();
        return t0 + ((t - t0) / per + 1) * per;
    endfunction

    initial begin
        int tr;
        // Ratio sweep: 512, 384, 256 each locked and compared cycle by cycle.
        for (int c = 2; c >= 0; c--) begin
            int p;
            p = (c == 2) ? 512 : (c == 1) ? 384 : 256;
            do_reset(2'(c));
            start_wc(p);
            acquire("R6");
            wave_en  = 1'b1;
            noerr_en = 1'b1;
            run_until(t + 3 * p);
            wave_en  = 1'b0;
            noerr_en = 1'b0;
        end

        // R11: reserved code while 256 is active keeps lock.
        ratio_sel = 2'd3;
        wave_en   = 1'b1;
        run_until(t + 3 * per);
        wave_en   = 1'b0;
        chk("R11", "lock after reserved code", int'(lock), 1);

        // R8: missing edge while aligned.
        tr = next_rise();
        run_until(tr + 200);
        wc_on = 1'b0;
        tr = next_rise();
        run_until(tr + 2);
        chk("R8", "no error before missing wrap", int'(align_err), 0);
        step();
        chk("R8", "error at missing edge", int'(align_err), 1);
        chk("R8", "lock dropped", int'(lock), 0);
        step();
        chk("R8", "error lasts one cycle", int'(align_err), 0);
        noerr_en = 1'b1;
        run_until(t + 2 * per);
        noerr_en = 1'b0;
        start_wc(per);
        acquire("R8");

        // R7: misplaced edge mid-frame.
        tr = next_rise();
        run_until(tr + 200);
        start_wc(per);
        run_until(t0 + 2);
        chk("R7", "no error before early edge", int'(align_err), 0);
        step();
        chk("R7", "error at early edge", int'(align_err), 1);
        chk("R7", "lock dropped", int'(lock), 0);
        step();
        chk("R7", "error lasts one cycle", int'(align_err), 0);
        run_until(t0 + per + 3);
        chk("R7", "realigned strobe", int'(frame_stb), 1);
        chk("R7", "no error on realign", int'(align_err), 0);
        run_until(t0 + 5 * per + 2);
        chk("R7", "lock before fourth frame", int'(lock), 0);
        step();
        chk("R7", "lock regained", int'(lock), 1);

        // R9: ratio change deferred to the boundary.
        tr = next_rise();
        run_until(tr - 150);
        ratio_sel = 2'd1;
        run_until(tr - 1);
        per = 384;
        t0  = tr;
        run_until(tr + 2);
        chk("R9", "lock held until boundary", int'(lock), 1);
        step();
        chk("R9", "strobe at old frame length", int'(frame_stb), 1);
        chk("R9", "lock dropped at boundary", int'(lock), 0);
        chk("R9", "no error at boundary", int'(align_err), 0);
        run_until(t0 + 384 + 3);
        chk("R9", "realigned at new ratio", int'(frame_stb), 1);
        chk("R9", "no error on realign", int'(align_err), 0);
        run_until(t0 + 5 * 384 + 2);
        chk("R9", "lock before fourth frame", int'(lock), 0);
        step();
        chk("R9", "lock at new ratio", int'(lock), 1);
        wave_en = 1'b1;
        run_until(t + 2 * 384);
        wave_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule